// File: doc/BRIEF.md
# Prefix-Tree Magnitude Comparator

This block compares two unsigned operands of equal width and raises exactly one of three flags: operand A larger, operand A smaller, or the two equal. It holds no state. It has no clock, no reset and no control input, so the flags follow the operands through the logic alone. It is meant for datapaths that need an ordering decision on every evaluation without the carry chain of a subtractor.

Arbitration runs from the top bit downward. A bit pair can decide the outcome only when every pair above it matches. Each bit forms an equality term from an XNOR of its two operand bits. The operand inverses are generated once and shared by all the cells. A prefix tree combines the equality terms into an "all bits above match" signal for every position. It first ANDs groups of four bits, then ANDs four such groups into a 16-bit block. That signal gates two per-bit winner vectors, one for each operand. Each winner vector is reduced by its own OR network, built from a 4-input level followed by a level that covers 16 bits. The equal flag is the NOR of the two network outputs. The operand width is a parameter and must be a multiple of 16.

Top module: `prefix_magnitude_cmp`

## Requirements
- R1: `a_gt_o` is 1 exactly when `a_i` is greater than `b_i` as unsigned numbers.
- R2: `a_lt_o` is 1 exactly when `a_i` is less than `b_i` as unsigned numbers.
- R3: `a_eq_o` is 1 exactly when `a_i` and `b_i` are identical in every bit.
- R4: For every input pair, exactly one of `a_gt_o`, `a_lt_o` and `a_eq_o` is 1.
- R5: The highest bit position at which the operands differ alone decides the result. Bits below it have no effect. For example, A=16'h8000 and B=16'h7FFF give `a_gt_o`=1.
- R6: When all higher bit pairs match, a difference in bit 0 alone decides the result. For example, A=16'h0001 and B=16'h0000 give `a_gt_o`=1.
- R7: The parameter `WIDTH` must be a positive multiple of 16. The comparator behaves per R1 to R4 at any such width, including 32.
- R8: The outputs are a pure function of the current inputs. A change on the operands is reflected without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A, unsigned |
| b_i | input | WIDTH | Operand B, unsigned |
| a_gt_o | output | 1 | A is greater than B |
| a_lt_o | output | 1 | A is less than B |
| a_eq_o | output | 1 | A equals B |

## Verification
Whenever the operands are known, the in-line assertions check that exactly one flag is raised and that each flag agrees with the unsigned relation of the operands. They also check that at most one bit position is marked as the winner across both winner vectors. The width rule is checked once at elaboration. Only the bench's scenarios show certain behaviours: that the top differing bit dominates over arbitrary lower bits, that a lone difference in bit 0 decides, and that the structure holds at a second width. The bench covers these with directed vectors, sweeps of the low nibble under several shared upper patterns, and random pairs.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
   // Fan-in of the first prefix and reduction level.
   localparam int unsigned GROUP_RADIX = 4;
   // Bits covered by one second-level node (GROUP_RADIX groups).
   localparam int unsigned BLOCK_BITS  = GROUP_RADIX * GROUP_RADIX;

   // Encoding of the outcome as {greater, less, equal}.
   typedef enum logic [2:0] {
      CMP_GT = 3'b100,
      CMP_LT = 3'b010,
      CMP_EQ = 3'b001
   } cmp_result_e;
endpackage

// File: rtl/pt_bit_cells.sv
module pt_bit_cells #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] bit_eq_o,
   output logic [WIDTH-1:0] a_bit_o,
   output logic [WIDTH-1:0] b_bit_o
);
   // Inverses generated once, shared by every cell below.
   logic [WIDTH-1:0] a_n, b_n;
   assign a_n = ~a_i;
   assign b_n = ~b_i;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      assign bit_eq_o[i] = ~(a_i[i] ^ b_i[i]);
      assign a_bit_o[i]  = a_i[i] & b_n[i];
      assign b_bit_o[i]  = a_n[i] & b_i[i];
   end
endmodule

// File: rtl/pt_eq_prefix.sv
module pt_eq_prefix
   import cmp_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] bit_eq_i,
   output logic [WIDTH-1:0] eq_above_o
);
   localparam int unsigned NGROUP = WIDTH / GROUP_RADIX;
   localparam int unsigned NBLOCK = WIDTH / BLOCK_BITS;

   logic [NGROUP-1:0] grp_eq;
   logic [NBLOCK-1:0] blk_eq;
   logic [NBLOCK-1:0] blk_above;

   for (genvar g = 0; g < NGROUP; g++) begin : g_grp
      assign grp_eq[g] = &bit_eq_i[g*GROUP_RADIX +: GROUP_RADIX];
   end

   for (genvar k = 0; k < NBLOCK; k++) begin : g_blk
      assign blk_eq[k] = &grp_eq[k*GROUP_RADIX +: GROUP_RADIX];
      if (k == NBLOCK - 1) begin : g_top
         assign blk_above[k] = 1'b1;
      end else begin : g_chain
         assign blk_above[k] = blk_above[k+1] & blk_eq[k+1];
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int unsigned GI   = i / GROUP_RADIX;
      localparam int unsigned KI   = i / BLOCK_BITS;
      localparam int unsigned GTOP = GI * GROUP_RADIX + GROUP_RADIX - 1;
      localparam int unsigned BTOP = KI * GROUP_RADIX + GROUP_RADIX - 1;
      logic in_grp, in_blk;
      always_comb begin
         in_grp = 1'b1;
         for (int j = i + 1; j <= GTOP; j++) in_grp = in_grp & bit_eq_i[j];
         in_blk = 1'b1;
         for (int h = GI + 1; h <= BTOP; h++) in_blk = in_blk & grp_eq[h];
      end
      assign eq_above_o[i] = in_grp & in_blk & blk_above[KI];
   end
endmodule

// File: rtl/pt_or_reduce.sv
module pt_or_reduce
   import cmp_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] win_i,
   output logic             any_o
);
   localparam int unsigned NGROUP = WIDTH / GROUP_RADIX;
   localparam int unsigned NBLOCK = WIDTH / BLOCK_BITS;

   logic [NGROUP-1:0] lvl1;
   logic [NBLOCK-1:0] lvl2;

   for (genvar g = 0; g < NGROUP; g++) begin : g_l1
      assign lvl1[g] = |win_i[g*GROUP_RADIX +: GROUP_RADIX];
   end
   for (genvar k = 0; k < NBLOCK; k++) begin : g_l2
      assign lvl2[k] = |lvl1[k*GROUP_RADIX +: GROUP_RADIX];
   end

   if (NBLOCK == 1) begin : g_single
      assign any_o = lvl2[0];
   end else begin : g_multi
      assign any_o = |lvl2;
   end
endmodule

// File: rtl/prefix_magnitude_cmp.sv
module prefix_magnitude_cmp
   import cmp_pkg::*;
#(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             a_gt_o,
   output logic             a_lt_o,
   output logic             a_eq_o
);
   initial begin
      assert_width_multiple_R7: assert (WIDTH >= BLOCK_BITS && (WIDTH % BLOCK_BITS) == 0)
         else $error("WIDTH %0d is not a positive multiple of %0d", WIDTH, BLOCK_BITS);
   end

   logic [WIDTH-1:0] bit_eq, a_bit, b_bit, eq_above, win_a, win_b;
   logic             any_a, any_b;

   pt_bit_cells #(.WIDTH(WIDTH)) i_cells (
      .a_i(a_i), .b_i(b_i),
      .bit_eq_o(bit_eq), .a_bit_o(a_bit), .b_bit_o(b_bit)
   );

   pt_eq_prefix #(.WIDTH(WIDTH)) i_prefix (
      .bit_eq_i(bit_eq), .eq_above_o(eq_above)
   );

   assign win_a = a_bit & eq_above;
   assign win_b = b_bit & eq_above;

   pt_or_reduce #(.WIDTH(WIDTH)) i_red_a (.win_i(win_a), .any_o(any_a));
   pt_or_reduce #(.WIDTH(WIDTH)) i_red_b (.win_i(win_b), .any_o(any_b));

   assign a_gt_o = any_a;
   assign a_lt_o = any_b;
   assign a_eq_o = ~(any_a | any_b);

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         assert_one_flag_R4: assert ($onehot({a_gt_o, a_lt_o, a_eq_o}))
            else $error("flags not one-hot");
         assert_gt_match_R1: assert (a_gt_o == (a_i > b_i))
            else $error("greater flag mismatch");
         assert_lt_match_R2: assert (a_lt_o == (a_i < b_i))
            else $error("less flag mismatch");
         assert_eq_match_R3: assert (a_eq_o == (a_i == b_i))
            else $error("equal flag mismatch");
         assert_single_winner_R5: assert ($onehot0(win_a | win_b))
            else $error("more than one deciding bit");
      end
   end
endmodule

// File: tb/test_prefix_magnitude_cmp.sv
module test_prefix_magnitude_cmp;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   // {a[15:0], b[15:0], {gt,lt,eq}}
   localparam logic [34:0] VEC [NVEC] = '{
      {16'h0000, 16'h0000, 3'b001},
      {16'hFFFF, 16'hFFFF, 3'b001},
      {16'hFFFF, 16'h0000, 3'b100},
      {16'h0000, 16'hFFFF, 3'b010},
      {16'h8000, 16'h7FFF, 3'b100},
      {16'h7FFF, 16'h8000, 3'b010},
      {16'h0001, 16'h0000, 3'b100},
      {16'hABCC, 16'hABCD, 3'b010},
      {16'h1234, 16'h1234, 3'b001},
      {16'h5A00, 16'h59FF, 3'b100}
   };

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [15:0] a16 = '0, b16 = '0;
   logic        gt16, lt16, eq16;
   logic [31:0] a32 = '0, b32 = '0;
   logic        gt32, lt32, eq32;

   prefix_magnitude_cmp #(.WIDTH(16)) i_prefix_magnitude_cmp (
      .a_i(a16), .b_i(b16), .a_gt_o(gt16), .a_lt_o(lt16), .a_eq_o(eq16));
   prefix_magnitude_cmp #(.WIDTH(32)) i_prefix_magnitude_cmp_w32 (
      .a_i(a32), .b_i(b32), .a_gt_o(gt32), .a_lt_o(lt32), .a_eq_o(eq32));

   task automatic judge(string req, logic [2:0] got, logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got {gt,lt,eq}=%b expected %b (a=%h b=%h)", req, got, exp, a16, b16);
      end
   endtask

   task automatic check16(string req, logic [15:0] a, logic [15:0] b);
      @(posedge clk);
      a16 = a; b16 = b;
      @(negedge clk);
      judge(req, {gt16, lt16, eq16}, {a > b, a < b, a == b});
   endtask

   initial begin
      // Initial inputs all zero: equal flag only (R3, R4).
      @(negedge clk);
      judge("R3", {gt16, lt16, eq16}, 3'b001);

      // Table walk.
      for (int v = 0; v < NVEC; v++) begin
         @(posedge clk);
         a16 = VEC[v][34:19]; b16 = VEC[v][18:3];
         @(negedge clk);
         judge(VEC[v][2] ? "R1" : (VEC[v][1] ? "R2" : "R3"), {gt16, lt16, eq16}, VEC[v][2:0]);
      end

      // Low-nibble sweep under shared upper bits (R6, R4).
      for (int h = 0; h < 3; h++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               logic [11:0] hi;
               hi = (h == 0) ? 12'h000 : ((h == 1) ? 12'hFFF : 12'hA5C);
               check16("R6", {hi, x[3:0]}, {hi, y[3:0]});
            end
         end
      end

      // Top differing bit dominates whatever lies below (R5).
      for (int k = 0; k < 40; k++) begin
         logic [15:0] r1, r2;
         int p;
         r1 = 16'($urandom);
         r2 = 16'($urandom);
         p  = k % 16;
         r2[15:0] = (r1 & ~((16'h1 << (p + 1)) - 16'h1)) | (r2 & ((16'h1 << p) - 16'h1));
         r1[p] = 1'b1;
         r2[p] = 1'b0;
         check16("R5", r1, r2);
         check16("R5", r2, r1);
      end

      // Random pairs (R1, R2).
      for (int k = 0; k < 200; k++) check16(k[0] ? "R1" : "R2", 16'($urandom), 16'($urandom));

      // Immediate response, no edge in between (R8).
      a16 = 16'h0100; b16 = 16'h00FF;
      #1;
      judge("R8", {gt16, lt16, eq16}, 3'b100);
      b16 = 16'h0100;
      #1;
      judge("R8", {gt16, lt16, eq16}, 3'b001);

      // 32-bit instance (R7).
      for (int k = 0; k < 60; k++) begin
         logic [31:0] x, y;
         x = $urandom;
         y = (k % 3 == 0) ? x : ((k % 3 == 1) ? (x ^ (32'h1 << (k % 32))) : $urandom);
         @(posedge clk);
         a32 = x; b32 = y;
         @(negedge clk);
         checks++;
         if ({gt32, lt32, eq32} !== {x > y, x < y, x == y}) begin
            errors++;
            $display("FAIL R7: got %b expected %b (a=%h b=%h)", {gt32, lt32, eq32},
                     {x > y, x < y, x == y}, x, y);
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule